// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out one atomic read-modify-write on a 32-bit word or a 64-bit doubleword for each accepted request. The pipeline hands it the raw instruction bits together with two register operands: operand B supplies the memory address and operand A supplies the data that is combined with the memory contents. The unit decodes the operation from the instruction and reads the old value through a simple request/response memory port. It computes the new value, writes it back and reports the old value for the destination register with a one-cycle done pulse.

Eight operations are supported: add, swap, AND, OR, and signed and unsigned minimum and maximum. Word forms work on the low 32 bits only, and they extend the returned old value by a rule that depends on the operation. Doubleword forms are only allowed when the 64-bit mode input is high. Any request that is not a legal operation finishes at once with an illegal-instruction flag and makes no memory access. Address and size stay fixed on the port from the read request until the write acknowledge, so the memory side can treat the pair as one locked transaction.

Top module: `amo_unit`

## Requirements
- R1: A request is a legal operation only when insn[31:25] = 7'h7a, insn[11:8] = 0 and the size field insn[14:12] is 2 (word) or 3 (doubleword). The operation is insn[7:5]: 0 add, 1 swap, 2 AND, 3 OR, 4 signed min, 5 signed max, 6 unsigned min, 7 unsigned max. Any other request completes with `illegal`=1, `result`=0 and no memory request.
- R2: A doubleword request (size 3) while `mode64`=0 completes with `illegal`=1 and no memory request. Word requests are legal in either mode.
- R3: A legal request makes exactly one read (`mem_req`=1, `mem_we`=0) at address operand B. After `mem_rvalid` it makes exactly one write (`mem_req`=1, `mem_we`=1), and `done` follows `mem_wack`.
- R4: `mem_addr` and `mem_dword` (1 = doubleword, 0 = word) keep the same value from the read request through the write acknowledge.
- R5: The written value is A+old for add, A for swap, A&old for AND and A|old for OR.
- R6: For doubleword min/max, the written value is the smaller or larger of A and old, compared as signed for ops 4/5 and unsigned for ops 6/7.
- R7: Word forms compare and combine only the low 32 bits of A and old, and the bits of A above 31 have no effect. The write carries the 32-bit result in `mem_wdata[31:0]` with `mem_wdata[63:32]` = 0.
- R8: `result` is the old memory value. For word forms it is sign-extended from bit 31 for ops 0 to 5 and zero-extended for ops 6 and 7.
- R9: `done` is a single-cycle pulse. `busy` is high from the cycle after acceptance through the done cycle, and requests presented while `busy`=1 are ignored.
- R10: After reset, `busy`, `done`, `illegal` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| insn | input | 32 | Instruction bits |
| opnd_a | input | 64 | Data operand |
| opnd_b | input | 64 | Address operand |
| mode64 | input | 1 | Enables doubleword forms |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Illegal instruction, valid with done |
| result | output | 64 | Old memory value, valid with done |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_dword | output | 1 | Access size: 1 doubleword, 0 word |
| mem_addr | output | 64 | Access address |
| mem_wdata | output | 64 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| mem_wack | input | 1 | Write acknowledge |

## Verification
A new request and the completion of the current one can land together: a request held on `req_valid` during the done cycle, while `busy` is still high, has to be dropped rather than started. The bench provokes this by driving a second, different operation for several cycles while the first is in flight. It then judges the outcome at the ports: one write only, with the first operation's value, a single done pulse, and no later activity on the memory port. A second overlap is an illegal decode arriving in the same cycle as acceptance. The bench checks that such a request completes straight away and never raises `mem_req`.

// File: rtl/amo_unit.sv
module amo_unit #(
  parameter int XW = 64,
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [31:0]   insn,
  input  logic [XW-1:0] opnd_a,
  input  logic [XW-1:0] opnd_b,
  input  logic          mode64,
  output logic          busy,
  output logic          done,
  output logic          illegal,
  output logic [XW-1:0] result,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_dword,
  output logic [XW-1:0] mem_addr,
  output logic [XW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [XW-1:0] mem_rdata,
  input  logic          mem_wack
);
  localparam int HW = XW - WW;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WAIT_RD, S_WRITE, S_WAIT_WACK, S_DONE} st_t;
  st_t st;

  logic [2:0]    op_q;
  logic          dw_q, ill_q;
  logic [XW-1:0] addr_q, a_q, new_q, res_q;

  wire is_amo = (insn[31:25] == 7'h7a) && (insn[11:8] == 4'd0);
  wire sz_w   = insn[14:12] == 3'd2;
  wire sz_d   = insn[14:12] == 3'd3;
  wire legal  = is_amo && (sz_w || (sz_d && mode64));
  wire accept = req_valid && (st == S_IDLE);

  wire [WW-1:0] a32 = a_q[WW-1:0];
  wire [WW-1:0] o32 = mem_rdata[WW-1:0];
  wire s_lt = dw_q ? ($signed(a_q) < $signed(mem_rdata)) : ($signed(a32) < $signed(o32));
  wire u_lt = dw_q ? (a_q < mem_rdata) : (a32 < o32);

  logic [XW-1:0] alu;
  always_comb begin
    case (op_q)
      3'd0: alu = a_q + mem_rdata;
      3'd1: alu = a_q;
      3'd2: alu = a_q & mem_rdata;
      3'd3: alu = a_q | mem_rdata;
      3'd4: alu = s_lt ? a_q : mem_rdata;
      3'd5: alu = s_lt ? mem_rdata : a_q;
      3'd6: alu = u_lt ? a_q : mem_rdata;
      default: alu = u_lt ? mem_rdata : a_q;
    endcase
  end

  wire [XW-1:0] new_v = dw_q ? alu : {{HW{1'b0}}, alu[WW-1:0]};
  wire [XW-1:0] old_v = dw_q ? mem_rdata :
                        (op_q[2:1] == 2'b11) ? {{HW{1'b0}}, o32} : {{HW{o32[WW-1]}}, o32};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= '0;
      dw_q   <= 1'b0;
      ill_q  <= 1'b0;
      addr_q <= '0;
      a_q    <= '0;
      new_q  <= '0;
      res_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_q   <= insn[7:5];
          dw_q   <= sz_d;
          ill_q  <= !legal;
          addr_q <= opnd_b;
          a_q    <= opnd_a;
          res_q  <= '0;
          st     <= legal ? S_READ : S_DONE;
        end
        S_READ: st <= S_WAIT_RD;
        S_WAIT_RD: if (mem_rvalid) begin
          new_q <= new_v;
          res_q <= old_v;
          st    <= S_WRITE;
        end
        S_WRITE: st <= S_WAIT_WACK;
        S_WAIT_WACK: if (mem_wack) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = st != S_IDLE;
  assign done      = st == S_DONE;
  assign illegal   = done && ill_q;
  assign result    = res_q;
  assign mem_req   = (st == S_READ) || (st == S_WRITE);
  assign mem_we    = st == S_WRITE;
  assign mem_dword = dw_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_q;

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_illegal_direct: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(req_valid));

  a_r4_port_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT_RD || st == S_WRITE || st == S_WAIT_WACK) |-> ($stable(mem_addr) && $stable(mem_dword)));

  a_r3_write_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_rvalid));

  a_r3_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r8_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && !dw_q && op_q[2:1] != 2'b11) |-> (result[XW-1:WW] == {HW{result[WW-1]}}));

  a_r8_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && !dw_q && op_q[2:1] == 2'b11) |-> (result[XW-1:WW] == '0));

  a_r7_word_store: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_dword) |-> (mem_wdata[XW-1:WW] == '0));
endmodule

// File: tb/test_amo_unit.sv
module test_amo_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic mode64 = 1'b1;
  logic busy, done, illegal, mem_req, mem_we, mem_dword;
  logic [63:0] result, mem_addr, mem_wdata;
  logic mem_rvalid = 1'b0, mem_wack = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #2 clk = ~clk;

  amo_unit i_amo_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .insn(insn),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .mode64(mode64),
    .busy(busy), .done(done), .illegal(illegal), .result(result),
    .mem_req(mem_req), .mem_we(mem_we), .mem_dword(mem_dword),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_wack(mem_wack)
  );

  logic [63:0] mem_val = '0, rd_addr, wr_addr, wr_data;
  logic rd_size, wr_size;
  int rd_cnt = 0, wr_cnt = 0, n_checks = 0, n_fail = 0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_wack   <= 1'b0;
    if (mem_req && !mem_we) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem_val;
      rd_addr    <= mem_addr;
      rd_size    <= mem_dword;
      rd_cnt     <= rd_cnt + 1;
    end
    if (mem_req && mem_we) begin
      mem_wack <= 1'b1;
      wr_addr  <= mem_addr;
      wr_data  <= mem_wdata;
      wr_size  <= mem_dword;
      wr_cnt   <= wr_cnt + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] opc, input logic [2:0] sz,
                                     input logic [3:0] hi, input logic [2:0] op);
    return {opc, 10'd0, sz, hi, op, 5'd0};
  endfunction

  typedef struct packed {
    logic [6:0]  opc;
    logic [2:0]  sz;
    logic [3:0]  hi;
    logic [2:0]  op;
    logic        m64;
    logic [63:0] a;
    logic [63:0] old;
    logic        ill;
    logic [63:0] w;
    logic [63:0] r;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{7'h7a, 3'd3, 4'd0, 3'd0, 1'b1, 64'd5, 64'd7, 1'b0, 64'd12, 64'd7},                       // R5 add
    '{7'h7a, 3'd3, 4'd0, 3'd1, 1'b1, 64'h1111, 64'h2222, 1'b0, 64'h1111, 64'h2222},            // R5 swap
    '{7'h7a, 3'd3, 4'd0, 3'd2, 1'b1, 64'hf0f0, 64'hff00, 1'b0, 64'hf000, 64'hff00},            // R5 and
    '{7'h7a, 3'd3, 4'd0, 3'd3, 1'b1, 64'hf0f0, 64'h0f00, 1'b0, 64'hfff0, 64'h0f00},            // R5 or
    '{7'h7a, 3'd3, 4'd0, 3'd4, 1'b1, '1, 64'd5, 1'b0, '1, 64'd5},                               // R6 min
    '{7'h7a, 3'd3, 4'd0, 3'd5, 1'b1, '1, 64'd5, 1'b0, 64'd5, 64'd5},                            // R6 max
    '{7'h7a, 3'd3, 4'd0, 3'd6, 1'b1, '1, 64'd5, 1'b0, 64'd5, 64'd5},                            // R6 minu
    '{7'h7a, 3'd3, 4'd0, 3'd7, 1'b1, '1, 64'd5, 1'b0, '1, 64'd5},                               // R6 maxu
    '{7'h7a, 3'd2, 4'd0, 3'd0, 1'b1, 64'hffffffff_00000001, 64'h12345678_80000000, 1'b0,
      64'h00000000_80000001, 64'hffffffff_80000000},                                           // R7 R8 word add
    '{7'h7a, 3'd2, 4'd0, 3'd4, 1'b1, 64'd1, 64'h00000000_fffffffe, 1'b0,
      64'h00000000_fffffffe, 64'hffffffff_fffffffe},                                           // R7 word min
    '{7'h7a, 3'd2, 4'd0, 3'd6, 1'b1, 64'd1, 64'h00000000_fffffffe, 1'b0,
      64'd1, 64'h00000000_fffffffe},                                                           // R8 word minu zero-ext
    '{7'h7a, 3'd2, 4'd0, 3'd5, 1'b1, 64'h00000000_80000000, 64'd1, 1'b0, 64'd1, 64'd1},        // R7 word max
    '{7'h7a, 3'd2, 4'd0, 3'd7, 1'b1, 64'hffffffff_00000003, 64'd2, 1'b0, 64'd3, 64'd2},        // R7 upper A ignored
    '{7'h7a, 3'd2, 4'd0, 3'd1, 1'b0, 64'haaaaaaaa_12345678, 64'hffffffff_00000001, 1'b0,
      64'h00000000_12345678, 64'd1},                                                           // R2 word legal without mode64
    '{7'h7a, 3'd3, 4'd0, 3'd0, 1'b0, 64'd1, 64'd2, 1'b1, 64'd0, 64'd0},                        // R2 dword illegal
    '{7'h7a, 3'd5, 4'd0, 3'd0, 1'b1, 64'd1, 64'd2, 1'b1, 64'd0, 64'd0},                        // R1 bad size
    '{7'h7a, 3'd3, 4'd4, 3'd0, 1'b1, 64'd1, 64'd2, 1'b1, 64'd0, 64'd0}                         // R1 masked bits set
  };

  task automatic run(input logic [31:0] ins, input logic m64, input logic [63:0] a,
                     input logic [63:0] b, input logic [63:0] old, output int lat);
    mem_val = old;
    @(negedge clk);
    insn = ins; mode64 = m64; opnd_a = a; opnd_b = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lat, r0, w0, extra;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !illegal && !mem_req, "R10 reset outputs",
        {busy, done, illegal, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [63:0] addr;
      addr = 64'h1000 + 64'(i * 8);
      r0 = rd_cnt; w0 = wr_cnt;
      run(mk(VEC[i].opc, VEC[i].sz, VEC[i].hi, VEC[i].op), VEC[i].m64, VEC[i].a, addr, VEC[i].old, lat);
      chk(done, "R9 done seen", done, 1);
      chk(illegal == VEC[i].ill, $sformatf("R1 R2 illegal flag v%0d", i), illegal, VEC[i].ill);
      chk(result == VEC[i].r, $sformatf("R8 result v%0d", i), result, VEC[i].r);
      @(negedge clk);
      chk(!done, "R9 done one cycle", done, 0);
      if (VEC[i].ill) begin
        chk(rd_cnt == r0 && wr_cnt == w0, $sformatf("R1 no memory access v%0d", i), rd_cnt - r0 + wr_cnt - w0, 0);
      end else begin
        chk(rd_cnt == r0 + 1 && wr_cnt == w0 + 1, $sformatf("R3 one read one write v%0d", i),
            rd_cnt - r0 + wr_cnt - w0, 2);
        chk(wr_data == VEC[i].w, $sformatf("R5 R6 R7 written value v%0d", i), wr_data, VEC[i].w);
        chk(rd_addr == addr && wr_addr == addr, $sformatf("R3 R4 address v%0d", i), wr_addr, addr);
        chk(rd_size == (VEC[i].sz == 3'd3) && wr_size == rd_size, $sformatf("R4 size v%0d", i),
            wr_size, VEC[i].sz == 3'd3);
      end
    end

    // R1: non-matching major opcode
    r0 = rd_cnt;
    run(mk(7'h7b, 3'd3, 4'd0, 3'd0), 1'b1, 64'd1, 64'h40, 64'd9, lat);
    chk(illegal && lat <= 2, "R1 other opcode illegal at once", lat, 2);
    @(negedge clk);
    chk(rd_cnt == r0, "R1 other opcode no read", rd_cnt - r0, 0);

    // R9: requests while busy ignored
    r0 = rd_cnt; w0 = wr_cnt;
    mem_val = 64'd10;
    @(negedge clk);
    insn = mk(7'h7a, 3'd3, 4'd0, 3'd0); opnd_a = 64'd1; opnd_b = 64'h200; mode64 = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    chk(busy, "R9 busy after accept", busy, 1);
    insn = mk(7'h7a, 3'd3, 4'd0, 3'd1); opnd_a = 64'd99; opnd_b = 64'h300;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(busy && done, "R9 busy through done", {busy, done}, 2'b11);
    chk(result == 64'd10, "R9 first result kept", result, 64'd10);
    @(negedge clk);
    req_valid = 1'b0;
    extra = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (done || mem_req) extra++;
    end
    chk(extra == 0, "R9 no second operation", extra, 0);
    chk(wr_cnt == w0 + 1 && rd_cnt == r0 + 1, "R9 single access pair", wr_cnt - w0, 1);
    chk(wr_data == 64'd11 && wr_addr == 64'h200, "R9 first operation written", wr_data, 64'd11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule